// File: doc/BRIEF.md
# CAN Bit Timer and Receive Sampler

This block divides each serial bit into time quanta and decides where in the bit the receive line is read. A one-clock quantum tick arrives from an external prescaler. Every bit starts with one synchronisation quantum. Time segment 1 follows it, and time segment 2 closes the bit. The receive line is read on the tick that ends segment 1. At that point the block either keeps the single reading or takes a majority vote of the last three quantum readings.

An 8-bit configuration word from the host sets the two segment lengths and the vote mode. The block adopts a new word only at a bit boundary or on a restart, so a bit already in progress keeps the timing it began with. A combinational flag marks configuration words whose segment lengths break the minimum-length rules. While the bus is idle, a recessive-to-dominant edge on the line restarts the bit at the synchronisation quantum. Outputs are the received bit, a sample strobe and a bit-end strobe.

Top module: `canBitTimer`

## Requirements
- R1: After reset the received bit is 1 (recessive), both strobes are 0, the active configuration is all zeros, and the two vote-history samples count as 1.
- R2: With configuration bits [3:0] = a and [6:4] = b, one bit lasts 1 + (a+1) + (b+1) quantum ticks. bitEndStb is high for exactly one clock, in the cycle after the tick that ends the bit.
- R3: sampleStb is high for exactly one clock, in the cycle after the tick that ends quantum number a+1, where the sync quantum is number 0.
- R4: When configuration bit 7 is 0, the received bit takes the value rxIn had on the sample tick.
- R5: When configuration bit 7 is 1, the received bit takes the majority of the rxIn values on the sample tick and on the two quantum ticks before it.
- R6: cfgErr is 1 whenever segment 1 is shorter than 4 quanta (bits [3:0] below 3).
- R7: cfgErr is 1 when segment 2 is 1 quantum (bits [6:4] = 0) and segment 1 is shorter than 5 quanta. cfgErr is 0 for every other word.
- R8: A configuration word is adopted only in the cycle that ends a bit or that restarts one. A change in the middle of a bit does not change that bit's timing or vote mode.
- R9: While busIdle is 1, a cycle in which rxIn is 0 and was 1 in the previous cycle restarts the bit at the sync quantum, with no strobe for that cycle. While busIdle is 0 such an edge has no effect on timing.
- R10: The received bit changes only in the cycle in which sampleStb is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| qTick | input | 1 | One-clock pulse that ends each time quantum |
| rxIn | input | 1 | Receive line, already synchronous; 1 is recessive |
| busIdle | input | 1 | High while no frame is in progress; enables restart on a falling edge |
| timingCfg | input | 8 | [7] vote mode, [6:4] segment 2 minus 1, [3:0] segment 1 minus 1 |
| rxBit | output | 1 | Received bit, updated at each sample point |
| sampleStb | output | 1 | One-clock pulse after each sample point |
| bitEndStb | output | 1 | One-clock pulse after each bit end |
| cfgErr | output | 1 | Combinational flag for a disallowed timingCfg |

## Verification
cfgErr is combinational, so it is checked 1 ns after timingCfg is driven, in the same cycle. rxBit, sampleStb and bitEndStb each pass through one register. The bench drives inputs on the falling edge and updates its reference model as though the next rising edge had happened. It compares the three outputs on the falling edge that follows, one clock after the deciding tick. Bit length is also measured directly as the number of cycles between bit-end pulses while ticks arrive every cycle.

// File: rtl/canBitPkg.sv
package canBitPkg;
  typedef struct packed {
    logic shiftNow;
    logic sampleNow;
    logic bitEnd;
    logic restart;
  } ctrlStb_t;
endpackage

// File: rtl/canCfgCheck.sv
module canCfgCheck #(
  parameter int T1_W = 4,
  parameter int T2_W = 3,
  parameter int MIN_T1 = 4,
  parameter int PROP_ALLOW = 3,
  parameter int MIN_PHASE = 2
) (
  input  logic [T1_W+T2_W:0] cfg,
  output logic               cfgErr
);
  localparam int T1_MIN_SHORT_T2 = PROP_ALLOW + MIN_PHASE;

  int t1Len;
  int t2Len;

  always_comb begin
    t1Len  = int'(cfg[T1_W-1:0]) + 1;
    t2Len  = int'(cfg[T1_W+T2_W-1:T1_W]) + 1;
    cfgErr = (t1Len < MIN_T1) || ((t2Len == 1) && (t1Len < T1_MIN_SHORT_T2));
  end
endmodule

// File: rtl/canBitCtrl.sv
module canBitCtrl
  import canBitPkg::*;
#(
  parameter int T1_W = 4,
  parameter int T2_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              qTick,
  input  logic              fallEdge,
  input  logic              busIdle,
  input  logic [T1_W+T2_W:0] cfgIn,
  output ctrlStb_t          stb,
  output logic              modeTriple
);
  localparam int CFG_W = T1_W + T2_W + 1;
  localparam int CNT_W = $clog2((2 ** T1_W) + (2 ** T2_W) + 1);

  logic [CFG_W-1:0] actCfg;
  logic [CNT_W-1:0] qCnt;
  logic [CNT_W-1:0] t1Len;
  logic [CNT_W-1:0] endIdx;
  logic             hardSync;
  logic             loadNow;

  always_comb begin
    t1Len    = CNT_W'(actCfg[T1_W-1:0]) + CNT_W'(1);
    endIdx   = t1Len + CNT_W'(actCfg[T1_W+T2_W-1:T1_W]) + CNT_W'(1);
    hardSync = busIdle && fallEdge;
    stb.restart   = hardSync;
    stb.shiftNow  = qTick;
    stb.sampleNow = qTick && !hardSync && (qCnt == t1Len);
    stb.bitEnd    = qTick && !hardSync && (qCnt == endIdx);
    loadNow    = stb.restart || stb.bitEnd;
    modeTriple = actCfg[CFG_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qCnt   <= '0;
      actCfg <= '0;
    end else if (loadNow) begin
      qCnt   <= '0;
      actCfg <= cfgIn;
    end else if (qTick) begin
      qCnt <= qCnt + CNT_W'(1);
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    qCnt <= endIdx); // R2
  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (actCfg != $past(actCfg)) |-> $past(loadNow)); // R8
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |=> (qCnt == '0)); // R9
endmodule

// File: rtl/canBitDatapath.sv
module canBitDatapath
  import canBitPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rxIn,
  input  ctrlStb_t stb,
  input  logic     modeTriple,
  output logic     fallEdge,
  output logic     rxBit,
  output logic     sampleStb,
  output logic     bitEndStb
);
  logic       prevRx;
  logic [1:0] hist;
  logic       vote;

  always_comb begin
    fallEdge = prevRx && !rxIn;
    vote = (hist[1] & hist[0]) | (hist[1] & rxIn) | (hist[0] & rxIn);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevRx    <= 1'b1;
      hist      <= 2'b11;
      rxBit     <= 1'b1;
      sampleStb <= 1'b0;
      bitEndStb <= 1'b0;
    end else begin
      prevRx    <= rxIn;
      sampleStb <= stb.sampleNow;
      bitEndStb <= stb.bitEnd;
      if (stb.shiftNow) hist <= {hist[0], rxIn};
      if (stb.sampleNow) rxBit <= modeTriple ? vote : rxIn;
    end
  end

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStb |-> (rxBit == $past(rxBit))); // R10
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleStb && bitEndStb)); // R3
  AST_SAMPLE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> $past(stb.shiftNow)); // R3
  AST_NO_STB_ON_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |=> !(sampleStb || bitEndStb)); // R9
endmodule

// File: rtl/canBitTimer.sv
module canBitTimer
  import canBitPkg::*;
#(
  parameter int T1_W = 4,
  parameter int T2_W = 3,
  parameter int MIN_T1 = 4,
  parameter int PROP_ALLOW = 3,
  parameter int MIN_PHASE = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                qTick,
  input  logic                rxIn,
  input  logic                busIdle,
  input  logic [T1_W+T2_W:0]  timingCfg,
  output logic                rxBit,
  output logic                sampleStb,
  output logic                bitEndStb,
  output logic                cfgErr
);
  ctrlStb_t stb;
  logic     modeTriple;
  logic     fallEdge;

  canBitCtrl #(.T1_W(T1_W), .T2_W(T2_W)) uCtrl (
    .clk(clk), .rstN(rstN), .qTick(qTick), .fallEdge(fallEdge),
    .busIdle(busIdle), .cfgIn(timingCfg), .stb(stb), .modeTriple(modeTriple)
  );

  canBitDatapath uData (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .stb(stb), .modeTriple(modeTriple),
    .fallEdge(fallEdge), .rxBit(rxBit), .sampleStb(sampleStb), .bitEndStb(bitEndStb)
  );

  canCfgCheck #(.T1_W(T1_W), .T2_W(T2_W), .MIN_T1(MIN_T1),
                .PROP_ALLOW(PROP_ALLOW), .MIN_PHASE(MIN_PHASE)) uCfg (
    .cfg(timingCfg), .cfgErr(cfgErr)
  );
endmodule

// File: tb/sim_canBitTimer.sv
module sim_canBitTimer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic qTick = 1'b0;
  logic rxIn = 1'b1;
  logic busIdle = 1'b0;
  logic [7:0] timingCfg = 8'h00;
  logic rxBit, sampleStb, bitEndStb, cfgErr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string tag = "R1";

  // reference model state
  int mCnt = 0;
  int mT1 = 1;
  int mT2 = 1;
  bit mMode = 0;
  bit [1:0] mHist = 2'b11;
  bit mPrev = 1;
  bit mRx = 1;
  bit mSs = 0;
  bit mBe = 0;
  int cyc = 0;
  int lastEnd = -1;
  int measureLen = 0;

  always #10 clk = ~clk;

  canBitTimer u0 (
    .clk(clk), .rstN(rstN), .qTick(qTick), .rxIn(rxIn), .busIdle(busIdle),
    .timingCfg(timingCfg), .rxBit(rxBit), .sampleStb(sampleStb),
    .bitEndStb(bitEndStb), .cfgErr(cfgErr)
  );

  function automatic bit expErr(logic [7:0] c);
    int t1 = int'(c[3:0]) + 1;
    int t2 = int'(c[6:4]) + 1;
    return (t1 < 4) || ((t2 == 1) && (t1 < 5));
  endfunction

  function automatic bit maj3(bit a, bit b, bit c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic loadCfg(logic [7:0] c);
    mT1 = int'(c[3:0]) + 1;
    mT2 = int'(c[6:4]) + 1;
    mMode = c[7];
  endtask

  task automatic step(bit tick, bit rx, bit idle, logic [7:0] cfg);
    @(negedge clk);
    chk(tag, "rxBit", int'(rxBit), int'(mRx));
    chk(tag, "sampleStb", int'(sampleStb), int'(mSs));
    chk(tag, "bitEndStb", int'(bitEndStb), int'(mBe));
    if (measureLen > 0 && bitEndStb) begin
      if (lastEnd >= 0) chk("R2", "bit length in cycles", cyc - lastEnd, measureLen);
      lastEnd = cyc;
    end
    cyc++;
    qTick = tick; rxIn = rx; busIdle = idle; timingCfg = cfg;
    #1;
    chk(expErr(cfg) && (cfg[3:0] < 4'd3) ? "R6" : "R7", "cfgErr", int'(cfgErr), int'(expErr(cfg)));
    mSs = 0; mBe = 0;
    if (idle && mPrev && !rx) begin
      mCnt = 0;
      loadCfg(cfg);
    end else if (tick) begin
      if (mCnt == mT1) begin
        mSs = 1;
        mRx = mMode ? maj3(mHist[1], mHist[0], rx) : rx;
      end
      if (mCnt == mT1 + mT2) begin
        mBe = 1;
        mCnt = 0;
        loadCfg(cfg);
      end else mCnt++;
    end
    if (tick) mHist = {mHist[0], rx};
    mPrev = rx;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete actual=0 expected=1");
    finish();
  end

  initial begin
    logic [7:0] c;
    bit r;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "rxBit after reset", int'(rxBit), 1);
    chk("R1", "sampleStb after reset", int'(sampleStb), 0);
    chk("R1", "bitEndStb after reset", int'(bitEndStb), 0);
    chk("R1", "cfgErr for zero config", int'(cfgErr), 1);

    // R6 R7: exhaustive configuration rule sweep with no ticks
    tag = "R6 R7";
    for (int i = 0; i < 256; i++) step(0, 1, 0, 8'(i));

    // R2 R3: steady timing with a tick every cycle, 6 + 3 + 1 = 10 quanta
    tag = "R2 R3";
    measureLen = 10;
    lastEnd = -1;
    for (int i = 0; i < 60; i++) step(1, 1, 0, 8'h25);
    measureLen = 0;

    // R8: configuration changes in the middle of bits
    tag = "R8";
    for (int i = 0; i < 80; i++) step(i[0], 1, 0, (i < 7) ? 8'h25 : 8'h47);
    c = 8'h36;
    for (int i = 0; i < 200; i++) begin
      if (i % 7 == 3) c = {1'($urandom), 3'($urandom), 4'(3 + $urandom % 13)};
      step(($urandom % 2) == 0, 1, 0, c);
    end

    // R4 R10: single-sample mode with random line data
    tag = "R4 R10";
    r = 1;
    for (int i = 0; i < 800; i++) begin
      if ($urandom % 3 == 0) r = ~r;
      step(($urandom % 2) == 0, r, 0, 8'h36);
    end

    // R5 R10: three-sample majority mode
    tag = "R5 R10";
    for (int i = 0; i < 800; i++) begin
      if ($urandom % 3 == 0) r = ~r;
      step(($urandom % 2) == 0, r, 0, 8'hB6);
    end

    // R9: idle restarts on falling edges
    tag = "R9";
    for (int i = 0; i < 600; i++) begin
      r = ($urandom % 9 != 0);
      step(($urandom % 2) == 0, r, 1, (i < 300) ? 8'h36 : 8'h94);
    end

    // mixed random traffic, idle toggled, occasional config changes
    tag = "R2 R3 R8 R9";
    c = 8'h47;
    for (int i = 0; i < 1500; i++) begin
      if ($urandom % 50 == 0) c = 8'($urandom);
      if ($urandom % 4 == 0) r = ~r;
      step(($urandom % 3) != 0, r, ($urandom % 4) == 0, c);
    end

    @(negedge clk);
    chk(tag, "final rxBit", int'(rxBit), int'(mRx));
    chk(tag, "final sampleStb", int'(sampleStb), int'(mSs));
    chk(tag, "final bitEndStb", int'(bitEndStb), int'(mBe));
    finish();
  end
endmodule